// File: doc/BRIEF.md
# Scaled Window Source Address Generator

This block walks the source image of one scaled display window. The source rectangle is `w` by `h` pixels. The output rectangle is `out_w` by `out_h` pixels. For every output pixel the block produces the byte address of the source pixel to fetch, plus the fractional horizontal and vertical phase that a filter downstream can use.

When a configuration is loaded, two sequential dividers compute one fixed-point step per axis. Each step is the source size times 4096 divided by the larger of (output size − 1) and 1, so it carries 12 fraction bits. When both quotients are known, the block raises `ready`. The display pipe then drives three strobes:
- a frame start, once per frame;
- a line advance, once per output line;
- a pixel advance, once per output pixel.

Each strobe steps or clears the horizontal and vertical accumulators. The integer part of each accumulator selects a source column or row. Column and row are offset by the programmed source origin and turned into an address using the line stride and the pixel size.

Two pixel formats are accepted: 16 bits per pixel and 32 bits per pixel. The narrow format raises a colour-expand flag for the pipe that follows. Pixel fetch, filtering and blending are outside this block.

Top module: `dda_scaler_agen`

## Requirements
- R1: The horizontal step equals floor(src_w·4096 / max(out_w−1, 1)). The vertical step is formed the same way from src_h and out_h. An output size of 0 or 1 uses a divisor of 1.
- R2: Both accumulators read zero after a configuration load and after a frame start. The horizontal accumulator also reads zero after each line advance.
- R3: The bits of an accumulator above bit 11 give the source column or row. The low 12 bits appear as `h_phase` and `v_phase`.
- R4: `src_addr` equals base + (off_y + row)·stride + (off_x + column)·B, taken modulo 2^AW. B is the number of bytes per pixel.
- R5: A depth code of 4 selects 16 bpp (B = 2) and sets `color_expand`. A code of 5 selects 32 bpp (B = 4) and clears `color_expand`. Any other code at load sets `cfg_err`, and `ready` stays low until a valid load.
- R6: `line_bytes` equals src_w·B. This is the prescaled width of one source line in bytes.
- R7: `ready` is low in the cycle after a load. It rises no later than SZW+14 cycles after the load.
- R8: Pixel and line advances have no effect while `ready` is low.
- R9: When a frame start and a line advance arrive in the same cycle, the vertical accumulator is cleared, not stepped.
- R10: After reset, `ready`, `cfg_err`, `color_expand`, `src_addr` and both phases are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Latch the configuration and start both dividers |
| cfg_src_w | input | SZW | Source width in pixels |
| cfg_src_h | input | SZW | Source height in lines |
| cfg_out_w | input | SZW | Output width in pixels |
| cfg_out_h | input | SZW | Output height in lines |
| cfg_off_x | input | SZW | Source column origin |
| cfg_off_y | input | SZW | Source row origin |
| cfg_stride | input | AW | Bytes between source lines |
| cfg_base | input | AW | Source buffer start address |
| cfg_depth | input | 3 | log2 of bits per pixel (4 or 5) |
| frame_start | input | 1 | Clear both accumulators |
| line_adv | input | 1 | Step vertical, clear horizontal |
| pix_adv | input | 1 | Step horizontal |
| ready | output | 1 | Steps are known and the configuration is valid |
| cfg_err | output | 1 | Last load carried an unsupported depth |
| color_expand | output | 1 | Loaded format is narrower than 24 bpp |
| line_bytes | output | SZW+2 | Source line width in bytes |
| src_addr | output | AW | Byte address of the current source pixel |
| h_phase | output | 12 | Horizontal fractional phase |
| v_phase | output | 12 | Vertical fractional phase |

## Verification
The bench builds the block with SZW = 8 and AW = 20. With these values each divider finishes in 20 cycles, so the `ready` latency bound can be checked exactly. Source sizes up to 255 make the step reach its largest form, 255·4096, when the output size is 1 or 2. A 20-bit address space lets row·stride products wrap, which exercises the modulo behaviour of the address sum. Pixel counts near the full output width push the accumulators close to their top bit.

// File: rtl/dda_pkg.sv
package dda_pkg;
    localparam int FRAC = 12;

    typedef enum logic [2:0] {
        DEPTH_16 = 3'd4,
        DEPTH_32 = 3'd5
    } depth_e;

    function automatic logic [1:0] bytes_shift(input logic [2:0] code);
        return (code == DEPTH_16) ? 2'd1 : 2'd2;
    endfunction
endpackage

// File: rtl/dda_div.sv
module dda_div #(
    parameter int NW = 20,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [NW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic          done_o,
    output logic [NW-1:0] quo_o
);
    localparam int CW = $clog2(NW + 1);
    localparam int PW = NW + DW;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [NW-1:0] q;
        logic [DW-1:0] r;
        logic [DW-1:0] den;
        logic [NW-1:0] num;
        logic [CW-1:0] cnt;
    } div_st_t;

    div_st_t s_d, s_q;
    logic [DW:0] sh;

    always_comb begin
        s_d = s_q;
        sh  = {s_q.r, s_q.q[NW-1]};
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.done = 1'b0;
            s_d.q    = num_i;
            s_d.r    = '0;
            s_d.den  = den_i;
            s_d.num  = num_i;
            s_d.cnt  = CW'(NW);
        end else if (s_q.busy) begin
            if (sh >= {1'b0, s_q.den}) begin
                s_d.r = DW'(sh - {1'b0, s_q.den});
                s_d.q = {s_q.q[NW-2:0], 1'b1};
            end else begin
                s_d.r = sh[DW-1:0];
                s_d.q = {s_q.q[NW-2:0], 1'b0};
            end
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CW'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o = s_q.done;
    assign quo_o  = s_q.q;

    // R1: a finished quotient and remainder reproduce the dividend
    a_r1_quotient_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && !s_q.busy) |->
        (PW'(s_q.q) * PW'(s_q.den) + PW'(s_q.r) == PW'(s_q.num)) && (s_q.r < s_q.den));

    // R7: a start always leaves the result marked not done
    a_r7_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o);
endmodule

// File: rtl/dda_axis.sv
module dda_axis #(
    parameter int ACCW = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            step_i,
    input  logic [ACCW-1:0] inc_i,
    output logic [ACCW-1:0] acc_o
);
    typedef struct packed {
        logic [ACCW-1:0] acc;
    } axis_st_t;

    axis_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i)       s_d.acc = '0;
        else if (step_i) s_d.acc = s_q.acc + inc_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc_o = s_q.acc;

    // R2: a clear leaves the accumulator at zero
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_o == '0));

    // R8: without a step or clear the accumulator holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !step_i) |=> $stable(acc_o));
endmodule

// File: rtl/dda_scaler_agen.sv
module dda_scaler_agen
    import dda_pkg::*;
#(
    parameter int SZW = 12,
    parameter int AW  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [SZW-1:0]   cfg_src_w,
    input  logic [SZW-1:0]   cfg_src_h,
    input  logic [SZW-1:0]   cfg_out_w,
    input  logic [SZW-1:0]   cfg_out_h,
    input  logic [SZW-1:0]   cfg_off_x,
    input  logic [SZW-1:0]   cfg_off_y,
    input  logic [AW-1:0]    cfg_stride,
    input  logic [AW-1:0]    cfg_base,
    input  logic [2:0]       cfg_depth,
    input  logic             frame_start,
    input  logic             line_adv,
    input  logic             pix_adv,
    output logic             ready,
    output logic             cfg_err,
    output logic             color_expand,
    output logic [SZW+1:0]   line_bytes,
    output logic [AW-1:0]    src_addr,
    output logic [FRAC-1:0]  h_phase,
    output logic [FRAC-1:0]  v_phase
);
    localparam int NW   = SZW + FRAC;
    localparam int ACCW = NW + 1;
    localparam int IW   = ACCW - FRAC;

    typedef struct packed {
        logic           err;
        logic [2:0]     depth;
        logic [SZW-1:0] src_w;
        logic [SZW-1:0] off_x;
        logic [SZW-1:0] off_y;
        logic [AW-1:0]  stride;
        logic [AW-1:0]  base;
    } cfg_st_t;

    cfg_st_t s_d, s_q;

    logic             depth_ok;
    logic [NW-1:0]    div_num  [2];
    logic [SZW-1:0]   div_den  [2];
    logic [NW-1:0]    div_quo  [2];
    logic             div_done [2];
    logic             ax_clr   [2];
    logic             ax_step  [2];
    logic [ACCW-1:0]  ax_acc   [2];
    logic [SZW-1:0]   size_in  [2];
    logic [SZW-1:0]   outs_in  [2];

    assign depth_ok   = (cfg_depth == DEPTH_16) || (cfg_depth == DEPTH_32);
    assign size_in[0] = cfg_src_w;
    assign size_in[1] = cfg_src_h;
    assign outs_in[0] = cfg_out_w;
    assign outs_in[1] = cfg_out_h;

    assign ready = div_done[0] && div_done[1] && !s_q.err;

    // axis 0 is horizontal, axis 1 is vertical
    assign ax_clr[0]  = cfg_load || frame_start || line_adv;
    assign ax_step[0] = pix_adv && ready;
    assign ax_clr[1]  = cfg_load || frame_start;
    assign ax_step[1] = line_adv && ready;

    for (genvar g = 0; g < 2; g++) begin : g_axis
        assign div_num[g] = {size_in[g], {FRAC{1'b0}}};
        assign div_den[g] = (outs_in[g] <= SZW'(1)) ? SZW'(1) : outs_in[g] - SZW'(1);

        dda_div #(.NW(NW), .DW(SZW)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (cfg_load && depth_ok),
            .num_i   (div_num[g]),
            .den_i   (div_den[g]),
            .done_o  (div_done[g]),
            .quo_o   (div_quo[g])
        );

        dda_axis #(.ACCW(ACCW)) u_axis (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (ax_clr[g]),
            .step_i (ax_step[g]),
            .inc_i  (ACCW'(div_quo[g])),
            .acc_o  (ax_acc[g])
        );
    end

    always_comb begin
        s_d = s_q;
        if (cfg_load) begin
            s_d.err = !depth_ok;
            if (depth_ok) begin
                s_d.depth  = cfg_depth;
                s_d.src_w  = cfg_src_w;
                s_d.off_x  = cfg_off_x;
                s_d.off_y  = cfg_off_y;
                s_d.stride = cfg_stride;
                s_d.base   = cfg_base;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.depth <= DEPTH_32;
        end else begin
            s_q <= s_d;
        end
    end

    logic [1:0]    bsh;
    logic [IW-1:0] col_i, row_i;
    logic [AW-1:0] row_a, col_a;

    always_comb begin
        bsh          = bytes_shift(s_q.depth);
        col_i        = ax_acc[0][ACCW-1:FRAC];
        row_i        = ax_acc[1][ACCW-1:FRAC];
        row_a        = AW'(s_q.off_y) + AW'(row_i);
        col_a        = AW'(s_q.off_x) + AW'(col_i);
        src_addr     = s_q.base + row_a * s_q.stride + (col_a << bsh);
        h_phase      = ax_acc[0][FRAC-1:0];
        v_phase      = ax_acc[1][FRAC-1:0];
        color_expand = (s_q.depth == DEPTH_16);
        line_bytes   = (SZW+2)'(s_q.src_w) << bsh;
        cfg_err      = s_q.err;
    end

    // R7: the cycle after a load never reports ready
    a_r7_load_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !ready);

    // R5: an unsupported depth blocks ready
    a_r5_err_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !ready);

    // R9: a frame start wins over a line advance on the vertical axis
    a_r9_frame_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && line_adv) |=> (v_phase == '0) && (ax_acc[1] == '0));

    // R2: a line advance returns the horizontal phase to zero
    a_r2_line_clears_h: assert property (@(posedge clk) disable iff (!rst_n)
        line_adv |=> (h_phase == '0));
endmodule

// File: tb/dda_scaler_agen_test.sv
module dda_scaler_agen_test;
    localparam int SZW  = 8;
    localparam int AW   = 20;
    localparam int NW   = SZW + 12;
    localparam int ACCW = NW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load = 0, frame_start = 0, line_adv = 0, pix_adv = 0;
    logic [SZW-1:0] src_w = 0, src_h = 0, out_w = 0, out_h = 0, off_x = 0, off_y = 0;
    logic [AW-1:0]  stride = 0, base = 0;
    logic [2:0]     depth = 3'd5;
    logic ready, cfg_err, color_expand;
    logic [SZW+1:0] line_bytes;
    logic [AW-1:0]  src_addr;
    logic [11:0]    h_phase, v_phase;

    int n_run = 0, n_fail = 0, cycles = 0;

    always #2 clk = ~clk;

    dda_scaler_agen #(.SZW(SZW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_src_w(src_w), .cfg_src_h(src_h), .cfg_out_w(out_w), .cfg_out_h(out_h),
        .cfg_off_x(off_x), .cfg_off_y(off_y), .cfg_stride(stride), .cfg_base(base),
        .cfg_depth(depth), .frame_start(frame_start), .line_adv(line_adv), .pix_adv(pix_adv),
        .ready(ready), .cfg_err(cfg_err), .color_expand(color_expand),
        .line_bytes(line_bytes), .src_addr(src_addr), .h_phase(h_phase), .v_phase(v_phase)
    );

    // w, h, out_w, out_h, off_x, off_y, stride, base, depth, lines, pixels
    localparam int NV = 6;
    localparam int VEC [NV][11] = '{
        '{100,  50, 200, 100,  3,  2,  200, 'h01000, 4,  5,   7},
        '{200, 120,  80,  60,  0,  0,  800, 'h08000, 5,  3,  10},
        '{ 64,  64,  64,  64,  1,  1,  128, 'h00200, 4, 63,  63},
        '{255, 255,   2,   2, 10, 20, 1020, 'h40000, 5,  1,   1},
        '{ 17,   9,   1,   1,  0,  0,   34, 'h00010, 4,  2,   3},
        '{ 33,  11, 250,   7,  5,  0,   66, 'h00123, 4,  0, 249}
    };

    function automatic longint step_of(input int sz, input int o);
        int d;
        d = (o <= 1) ? 1 : o - 1;
        return (longint'(sz) * 4096) / d;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic do_load(input int v[11]);
        src_w = SZW'(v[0]); src_h = SZW'(v[1]); out_w = SZW'(v[2]); out_h = SZW'(v[3]);
        off_x = SZW'(v[4]); off_y = SZW'(v[5]); stride = AW'(v[6]); base = AW'(v[7]);
        depth = 3'(v[8]);
        cfg_load = 1; tick(); cfg_load = 0;
    endtask

    task automatic wait_ready(output int lat);
        lat = 1;
        while (!ready && lat < 200) begin tick(); lat++; end
    endtask

    task automatic pulse_line(); line_adv = 1; tick(); line_adv = 0; endtask
    task automatic pulse_pix();  pix_adv = 1;  tick(); pix_adv = 0;  endtask
    task automatic pulse_frame(); frame_start = 1; tick(); frame_start = 0; endtask

    task automatic check_point(input int v[11], input int nl, input int np, input string tag);
        longint hacc, vacc, hi, vi, bpp, ea;
        hacc = (np * step_of(v[0], v[2])) % (longint'(1) << ACCW);
        vacc = (nl * step_of(v[1], v[3])) % (longint'(1) << ACCW);
        hi = hacc >> 12; vi = vacc >> 12;
        bpp = (v[8] == 4) ? 2 : 4;
        ea = (longint'(v[7]) + (v[5] + vi) * v[6] + (v[4] + hi) * bpp) % (longint'(1) << AW);
        check({tag, " R1 R3 h_phase"}, h_phase, hacc % 4096);
        check({tag, " R1 R3 v_phase"}, v_phase, vacc % 4096);
        check({tag, " R4 src_addr"}, src_addr, ea);
    endtask

    initial begin
        int lat;
        int d[11];
        repeat (3) tick();
        // R10: reset state
        check("R10 ready", ready, 0);
        check("R10 cfg_err", cfg_err, 0);
        check("R10 color_expand", color_expand, 0);
        check("R10 src_addr", src_addr, 0);
        check("R10 phases", {h_phase, v_phase}, 0);
        rst_n = 1; tick();

        for (int i = 0; i < NV; i++) begin
            do_load(VEC[i]);
            check("R7 ready low after load", ready, 0);
            wait_ready(lat);
            check("R7 ready latency bound", (lat <= NW + 2) ? 1 : 0, 1);
            check("R5 color_expand", color_expand, (VEC[i][8] == 4) ? 1 : 0);
            check("R6 line_bytes", line_bytes, VEC[i][0] * ((VEC[i][8] == 4) ? 2 : 4));
            pulse_frame();
            for (int l = 0; l < VEC[i][9]; l++) pulse_line();
            for (int p = 0; p < VEC[i][10]; p++) pulse_pix();
            check_point(VEC[i], VEC[i][9], VEC[i][10], "vec");
        end

        // R8: advances while dividers run are ignored
        d = '{90, 40, 30, 20, 4, 6, 300, 'h00500, 5, 0, 0};
        do_load(d);
        pulse_pix(); pulse_line(); pulse_pix();
        wait_ready(lat);
        check("R8 h_phase held", h_phase, 0);
        check("R8 src_addr held", src_addr, 'h500 + 6 * 300 + 4 * 4);

        // R2: line advance clears horizontal, keeps vertical
        pulse_frame();
        pulse_line(); pulse_line();
        pulse_pix(); pulse_pix(); pulse_pix();
        pulse_line();
        check_point(d, 3, 0, "R2 line clear");
        // R9: frame start and line advance together
        pulse_pix();
        frame_start = 1; line_adv = 1; tick(); frame_start = 0; line_adv = 0;
        check("R9 v_phase cleared", v_phase, 0);
        check("R2 R9 src_addr at origin", src_addr, 'h500 + 6 * 300 + 4 * 4);

        // R5: unsupported depth
        d[8] = 6;
        do_load(d);
        repeat (NW + 4) tick();
        check("R5 cfg_err set", cfg_err, 1);
        check("R5 ready blocked", ready, 0);
        pulse_pix();
        check("R5 R8 h_phase while err", h_phase, 0);
        d[8] = 5;
        do_load(d);
        check("R5 cfg_err cleared", cfg_err, 0);
        wait_ready(lat);
        check("R5 R7 ready after valid load", ready, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule